// File: doc/BRIEF.md
# Framebuffer Viewport Burst Address Generator

This block walks a visible window inside a wider virtual framebuffer held in memory and turns it into a stream of burst read requests. Software programs a start address, the number of 32-bit words in one visible line, the number of bytes to jump over between the end of one visible line and the start of the next, the total number of words in the frame, a burst size and a sub-word pixel offset. Once enabled, the generator issues one burst request at a time, each carrying a byte address and a length in words minus one. It waits for the memory side to report that the burst has finished before it moves on.

Bursts never straddle the end of a visible line or the end of the frame; the last burst of a line or of the frame is shortened to what remains. When a line runs out, the skip distance is added so that the next line starts at the right place in the virtual image. When the frame's word count is used up, an end-of-frame pulse is raised and addressing starts again from the start address. Start address, skip and pixel offset are double-buffered. A write to them is staged and only takes effect at the next frame start after an update request has been made. The request flag clears itself when the staged values are taken.

Top module: `fb_burst_agu`

## Requirements
- R1: After reset, req_valid, busy, eof and upd_pending are all low.
- R2: The first burst of a frame starts at the active start address, and req_len carries the burst word count minus one. The burst word count is the smallest of (burst field + 1), the words left in the line and the words left in the frame.
- R3: Within one visible line, each burst address equals the previous burst address plus 4 times the previous burst's word count.
- R4: When a burst finishes a visible line, the next burst address is the previous address plus 4 times its word count plus the active skip byte count. The next line again has the full programmed line word count.
- R5: When the frame's word count is used up, eof is high for exactly one cycle, in the cycle after the rsp_done of the last burst. The next burst, if enabled, starts at the start address.
- R6: Writes to the staged start address, skip and pixel offset (register selects 1, 2 and 3) change nothing until the update bit (bit 1 of a write to select 0) is set. They are applied at the next frame start. upd_pending is high from the update write until that frame start.
- R7: Without an update request, staged values are ignored across frame boundaries, and the old start address and pixel offset remain in use.
- R8: While req_valid is high and req_ready is low, req_valid stays high and req_addr and req_len hold their values.
- R9: Clearing the enable bit (bit 0 of a write to select 0) lets the burst in progress finish. After its rsp_done no new request is issued and busy goes low.
- R10: busy is high from the frame start until the generator returns to idle, and req_valid is never high while busy is low.
- R11: At most one burst is outstanding: req_valid stays low from an accepted request until its rsp_done.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_we | input | 1 | Register write strobe |
| cfg_sel | input | 3 | Register select: 0 control, 1 start address, 2 skip bytes, 3 pixel offset, 4 frame words, 5 line words, 6 burst words minus one |
| cfg_wdata | input | 32 | Register write data |
| busy | output | 1 | Generator is in a frame |
| upd_pending | output | 1 | Update request not yet taken |
| req_valid | output | 1 | Burst request present |
| req_ready | input | 1 | Memory side accepts the request |
| req_addr | output | 32 | Byte address of the burst's first word |
| req_len | output | 4 | Burst word count minus one |
| req_pixoff | output | 5 | Active sub-word pixel offset |
| rsp_done | input | 1 | The accepted burst has completed |
| eof | output | 1 | End-of-frame pulse |

## Verification
The assertions assume that the memory side obeys the request handshake. rsp_done comes only for a burst that was accepted, at most once, and never while a request is still waiting. They also assume that frame words, line words and burst size change only while busy is low and are never zero. The bench's responder model raises rsp_done exactly once after each accepted request. Every size register is programmed only after the generator has been stopped and its last burst has been retired.

// File: rtl/fbagu_pkg.sv
package fbagu_pkg;

  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_REQ  = 2'd1,
    ST_WAIT = 2'd2
  } agu_state_e;

  localparam logic [2:0] SEL_CTRL  = 3'd0;
  localparam logic [2:0] SEL_BASE  = 3'd1;
  localparam logic [2:0] SEL_SKIP  = 3'd2;
  localparam logic [2:0] SEL_PIX   = 3'd3;
  localparam logic [2:0] SEL_FRAME = 3'd4;
  localparam logic [2:0] SEL_LINE  = 3'd5;
  localparam logic [2:0] SEL_BLEN  = 3'd6;

  localparam int CTRL_EN_BIT  = 0;
  localparam int CTRL_UPD_BIT = 1;

endpackage

// File: rtl/fbagu_regs.sv
module fbagu_regs
  import fbagu_pkg::*;
#(
  parameter int DATA_W = 32,
  parameter int ADDR_W = 32,
  parameter int SKIP_W = 16,
  parameter int PO_W   = 5,
  parameter int FW_W   = 24,
  parameter int LW_W   = 16,
  parameter int BL_W   = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cfg_we,
  input  logic [2:0]        cfg_sel,
  input  logic [DATA_W-1:0] cfg_wdata,
  input  logic              frame_start,
  output logic              en,
  output logic              pend,
  output logic [ADDR_W-1:0] eff_base,
  output logic [SKIP_W-1:0] act_skip,
  output logic [PO_W-1:0]   act_pix,
  output logic [FW_W-1:0]   frame_words,
  output logic [LW_W-1:0]   line_words,
  output logic [BL_W-1:0]   blen
);

  logic              en_q, en_n;
  logic              pend_q, pend_n;
  logic [ADDR_W-1:0] sh_base_q, sh_base_n, act_base_q, act_base_n;
  logic [SKIP_W-1:0] sh_skip_q, sh_skip_n, act_skip_q, act_skip_n;
  logic [PO_W-1:0]   sh_pix_q, sh_pix_n, act_pix_q, act_pix_n;
  logic [FW_W-1:0]   fw_q, fw_n;
  logic [LW_W-1:0]   lw_q, lw_n;
  logic [BL_W-1:0]   bl_q, bl_n;

  always_comb begin
    en_n       = en_q;
    pend_n     = pend_q;
    sh_base_n  = sh_base_q;
    sh_skip_n  = sh_skip_q;
    sh_pix_n   = sh_pix_q;
    act_base_n = act_base_q;
    act_skip_n = act_skip_q;
    act_pix_n  = act_pix_q;
    fw_n       = fw_q;
    lw_n       = lw_q;
    bl_n       = bl_q;
    if (frame_start && pend_q) begin
      act_base_n = sh_base_q;
      act_skip_n = sh_skip_q;
      act_pix_n  = sh_pix_q;
      pend_n     = 1'b0;
    end
    if (cfg_we) begin
      case (cfg_sel)
        SEL_CTRL: begin
          en_n = cfg_wdata[CTRL_EN_BIT];
          if (cfg_wdata[CTRL_UPD_BIT]) pend_n = 1'b1;
        end
        SEL_BASE:  sh_base_n = cfg_wdata[ADDR_W-1:0];
        SEL_SKIP:  sh_skip_n = cfg_wdata[SKIP_W-1:0];
        SEL_PIX:   sh_pix_n  = cfg_wdata[PO_W-1:0];
        SEL_FRAME: fw_n      = cfg_wdata[FW_W-1:0];
        SEL_LINE:  lw_n      = cfg_wdata[LW_W-1:0];
        SEL_BLEN:  bl_n      = cfg_wdata[BL_W-1:0];
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      en_q       <= 1'b0;
      pend_q     <= 1'b0;
      sh_base_q  <= '0;
      sh_skip_q  <= '0;
      sh_pix_q   <= '0;
      act_base_q <= '0;
      act_skip_q <= '0;
      act_pix_q  <= '0;
      fw_q       <= '0;
      lw_q       <= '0;
      bl_q       <= '0;
    end else begin
      en_q       <= en_n;
      pend_q     <= pend_n;
      sh_base_q  <= sh_base_n;
      sh_skip_q  <= sh_skip_n;
      sh_pix_q   <= sh_pix_n;
      act_base_q <= act_base_n;
      act_skip_q <= act_skip_n;
      act_pix_q  <= act_pix_n;
      fw_q       <= fw_n;
      lw_q       <= lw_n;
      bl_q       <= bl_n;
    end
  end

  assign en          = en_q;
  assign pend        = pend_q;
  assign eff_base    = pend_q ? sh_base_q : act_base_q;
  assign act_skip    = act_skip_q;
  assign act_pix     = act_pix_q;
  assign frame_words = fw_q;
  assign line_words  = lw_q;
  assign blen        = bl_q;

endmodule

// File: rtl/fbagu_seq.sv
module fbagu_seq
  import fbagu_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic en,
  input  logic req_ready,
  input  logic rsp_done,
  input  logic last,
  output logic frame_start,
  output logic step,
  output logic req_valid,
  output logic busy,
  output logic eof
);

  agu_state_e st_q, st_n;
  logic       eof_q, eof_n;

  always_comb begin
    st_n        = st_q;
    step        = 1'b0;
    frame_start = 1'b0;
    case (st_q)
      ST_IDLE: begin
        if (en) begin
          frame_start = 1'b1;
          st_n        = ST_REQ;
        end
      end
      ST_REQ: begin
        if (req_ready) st_n = ST_WAIT;
      end
      ST_WAIT: begin
        if (rsp_done) begin
          step = 1'b1;
          if (en) begin
            frame_start = last;
            st_n        = ST_REQ;
          end else begin
            st_n = ST_IDLE;
          end
        end
      end
      default: st_n = ST_IDLE;
    endcase
    eof_n = step && last;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q  <= ST_IDLE;
      eof_q <= 1'b0;
    end else begin
      st_q  <= st_n;
      eof_q <= eof_n;
    end
  end

  assign req_valid = (st_q == ST_REQ);
  assign busy      = (st_q != ST_IDLE);
  assign eof       = eof_q;

endmodule

// File: rtl/fbagu_addr.sv
module fbagu_addr #(
  parameter int ADDR_W = 32,
  parameter int SKIP_W = 16,
  parameter int FW_W   = 24,
  parameter int LW_W   = 16,
  parameter int BL_W   = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              frame_start,
  input  logic              step,
  input  logic [ADDR_W-1:0] base,
  input  logic [SKIP_W-1:0] skip,
  input  logic [FW_W-1:0]   frame_words,
  input  logic [LW_W-1:0]   line_words,
  input  logic [BL_W-1:0]   blen,
  output logic [ADDR_W-1:0] req_addr,
  output logic [BL_W-1:0]   req_len,
  output logic              last
);

  localparam int CNT_W = (FW_W > LW_W) ? FW_W : LW_W;
  localparam int N_W   = BL_W + 1;

  logic [ADDR_W-1:0] addr_q, addr_n;
  logic [LW_W-1:0]   ll_q, ll_n;
  logic [FW_W-1:0]   fl_q, fl_n;

  logic [CNT_W-1:0]  ll_ext, fl_ext, bl_ext, cand, n_ext;
  logic [N_W-1:0]    n_words;
  logic              line_end;
  logic [ADDR_W-1:0] adv;

  always_comb begin
    ll_ext = CNT_W'(ll_q);
    fl_ext = CNT_W'(fl_q);
    bl_ext = CNT_W'(blen) + CNT_W'(1);
    cand   = bl_ext;
    if (ll_ext < cand) cand = ll_ext;
    if (fl_ext < cand) cand = fl_ext;
    n_words  = cand[N_W-1:0];
    n_ext    = CNT_W'(n_words);
    line_end = (ll_ext == n_ext);
    last     = (fl_ext == n_ext);
    adv      = ADDR_W'(n_words) << 2;
    if (line_end) adv = adv + ADDR_W'(skip);
  end

  always_comb begin
    addr_n = addr_q;
    ll_n   = ll_q;
    fl_n   = fl_q;
    if (frame_start) begin
      addr_n = base;
      ll_n   = line_words;
      fl_n   = frame_words;
    end else if (step) begin
      addr_n = addr_q + adv;
      ll_n   = line_end ? line_words : LW_W'(ll_ext - n_ext);
      fl_n   = FW_W'(fl_ext - n_ext);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      addr_q <= '0;
      ll_q   <= '0;
      fl_q   <= '0;
    end else begin
      addr_q <= addr_n;
      ll_q   <= ll_n;
      fl_q   <= fl_n;
    end
  end

  assign req_addr = addr_q;
  assign req_len  = BL_W'(n_words - N_W'(1));

endmodule

// File: rtl/fb_burst_agu.sv
module fb_burst_agu #(
  parameter int DATA_W = 32,
  parameter int ADDR_W = 32,
  parameter int SKIP_W = 16,
  parameter int PO_W   = 5,
  parameter int FW_W   = 24,
  parameter int LW_W   = 16,
  parameter int BL_W   = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cfg_we,
  input  logic [2:0]        cfg_sel,
  input  logic [DATA_W-1:0] cfg_wdata,
  output logic              busy,
  output logic              upd_pending,
  output logic              req_valid,
  input  logic              req_ready,
  output logic [ADDR_W-1:0] req_addr,
  output logic [BL_W-1:0]   req_len,
  output logic [PO_W-1:0]   req_pixoff,
  input  logic              rsp_done,
  output logic              eof
);

  logic              en, frame_start, step, last;
  logic [ADDR_W-1:0] eff_base;
  logic [SKIP_W-1:0] act_skip;
  logic [FW_W-1:0]   frame_words;
  logic [LW_W-1:0]   line_words;
  logic [BL_W-1:0]   blen;

  fbagu_regs #(
    .DATA_W(DATA_W), .ADDR_W(ADDR_W), .SKIP_W(SKIP_W), .PO_W(PO_W),
    .FW_W(FW_W), .LW_W(LW_W), .BL_W(BL_W)
  ) u_regs (
    .clk         (clk),
    .rst_n       (rst_n),
    .cfg_we      (cfg_we),
    .cfg_sel     (cfg_sel),
    .cfg_wdata   (cfg_wdata),
    .frame_start (frame_start),
    .en          (en),
    .pend        (upd_pending),
    .eff_base    (eff_base),
    .act_skip    (act_skip),
    .act_pix     (req_pixoff),
    .frame_words (frame_words),
    .line_words  (line_words),
    .blen        (blen)
  );

  fbagu_seq u_seq (
    .clk         (clk),
    .rst_n       (rst_n),
    .en          (en),
    .req_ready   (req_ready),
    .rsp_done    (rsp_done),
    .last        (last),
    .frame_start (frame_start),
    .step        (step),
    .req_valid   (req_valid),
    .busy        (busy),
    .eof         (eof)
  );

  fbagu_addr #(
    .ADDR_W(ADDR_W), .SKIP_W(SKIP_W), .FW_W(FW_W), .LW_W(LW_W), .BL_W(BL_W)
  ) u_addr (
    .clk         (clk),
    .rst_n       (rst_n),
    .frame_start (frame_start),
    .step        (step),
    .base        (eff_base),
    .skip        (act_skip),
    .frame_words (frame_words),
    .line_words  (line_words),
    .blen        (blen),
    .req_addr    (req_addr),
    .req_len     (req_len),
    .last        (last)
  );

endmodule

// File: rtl/fbagu_chk.sv
module fbagu_chk #(
  parameter int ADDR_W = 32,
  parameter int BL_W   = 4
) (
  input logic              clk,
  input logic              rst_n,
  input logic              req_valid,
  input logic              req_ready,
  input logic [ADDR_W-1:0] req_addr,
  input logic [BL_W-1:0]   req_len,
  input logic              rsp_done,
  input logic              busy,
  input logic              eof
);

  logic outstanding_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) outstanding_q <= 1'b0;
    else if (req_valid && req_ready) outstanding_q <= 1'b1;
    else if (rsp_done) outstanding_q <= 1'b0;
  end

  AST_REQ_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && !req_ready) |=> (req_valid && $stable(req_addr) && $stable(req_len))); // R8

  AST_EOF_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
    eof |=> !eof); // R5

  AST_EOF_AFTER_DONE: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(eof) |-> $past(rsp_done)); // R5

  AST_IDLE_NO_REQ: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> !req_valid); // R10

  AST_ONE_OUTSTANDING: assert property (@(posedge clk) disable iff (!rst_n)
    outstanding_q |-> !req_valid); // R11

endmodule

bind fb_burst_agu fbagu_chk #(.ADDR_W(ADDR_W), .BL_W(BL_W)) u_fbagu_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .req_valid (req_valid),
  .req_ready (req_ready),
  .req_addr  (req_addr),
  .req_len   (req_len),
  .rsp_done  (rsp_done),
  .busy      (busy),
  .eof       (eof)
);

// File: tb/test_fb_burst_agu.sv
module test_fb_burst_agu;

  localparam int CLK_PERIOD = 10;
  localparam int WDOG_CYCLES = 50000;

  logic        clk;
  logic        rst_n;
  logic        cfg_we;
  logic [2:0]  cfg_sel;
  logic [31:0] cfg_wdata;
  logic        busy, upd_pending, req_valid, req_ready, rsp_done, eof;
  logic [31:0] req_addr;
  logic [3:0]  req_len;
  logic [4:0]  req_pixoff;

  int n_checks = 0;
  int n_fails  = 0;

  fb_burst_agu i_fb_burst_agu (
    .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_sel(cfg_sel),
    .cfg_wdata(cfg_wdata), .busy(busy), .upd_pending(upd_pending),
    .req_valid(req_valid), .req_ready(req_ready), .req_addr(req_addr),
    .req_len(req_len), .req_pixoff(req_pixoff), .rsp_done(rsp_done), .eof(eof)
  );

  initial clk = 1'b0;
  always #(CLK_PERIOD/2) clk = ~clk;

  task automatic check(input bit ok, input string req, input longint act, input longint exp);
    n_checks++;
    if (!ok) begin
      n_fails++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [2:0] sel, input logic [31:0] data);
    @(negedge clk);
    cfg_we = 1'b1; cfg_sel = sel; cfg_wdata = data;
    @(negedge clk);
    cfg_we = 1'b0;
  endtask

  task automatic wait_req(input string req);
    int n = 0;
    while (!req_valid && n < 40) begin
      @(negedge clk);
      n++;
    end
    check(req_valid, req, req_valid, 1);
  endtask

  // one burst: check request, optional ready stall, accept, retire, check eof
  task automatic burst(input logic [31:0] exp_addr, input int words, input bit exp_eof,
                       input int stall, input string req);
    logic [31:0] a0;
    wait_req(req);
    check(req_addr == exp_addr, req, req_addr, exp_addr);
    check(req_len == 4'(words - 1), req, req_len, words - 1);
    a0 = req_addr;
    for (int i = 0; i < stall; i++) begin
      @(negedge clk);
      check(req_valid && req_addr == a0, "R8", req_addr, a0);
    end
    req_ready = 1'b1;
    @(negedge clk);
    req_ready = 1'b0;
    check(!req_valid, "R11", req_valid, 0);
    check(busy, "R10", busy, 1);
    rsp_done = 1'b1;
    @(negedge clk);
    rsp_done = 1'b0;
    check(eof == exp_eof, "R5", eof, exp_eof);
    if (exp_eof) begin
      @(negedge clk);
      check(!eof, "R5", eof, 0);
    end
  endtask

  task automatic stop_engine(input logic [31:0] exp_addr, input int words);
    wr(3'd0, 32'h0);
    burst(exp_addr, words, 1'b0, 0, "R9");
    for (int i = 0; i < 5; i++) begin
      @(negedge clk);
      check(!req_valid, "R9", req_valid, 0);
      check(!busy, "R9", busy, 0);
    end
  endtask

  task automatic t_reset;
    check(!req_valid, "R1", req_valid, 0);
    check(!busy, "R1", busy, 0);
    check(!eof, "R1", eof, 0);
    check(!upd_pending, "R1", upd_pending, 0);
  endtask

  // 3 lines of 10 words, skip 8 bytes, 8-word bursts
  task automatic t_line_walk;
    wr(3'd1, 32'h1000); wr(3'd2, 32'd8); wr(3'd3, 32'd3);
    wr(3'd4, 32'd30); wr(3'd5, 32'd10); wr(3'd6, 32'd7);
    wr(3'd0, 32'h3);
    wait_req("R2");
    check(req_pixoff == 5'd3, "R6", req_pixoff, 3);
    check(!upd_pending, "R6", upd_pending, 1'b0);
    burst(32'h1000, 8, 1'b0, 0, "R2");
    burst(32'h1020, 2, 1'b0, 0, "R3");
    burst(32'h1030, 8, 1'b0, 0, "R4");
    burst(32'h1050, 2, 1'b0, 0, "R4");
    burst(32'h1060, 8, 1'b0, 2, "R4");
    burst(32'h1080, 2, 1'b1, 0, "R5");
    stop_engine(32'h1000, 8);
  endtask

  // frame ends mid-line: 13 words in a 20-word line
  task automatic t_frame_clip;
    wr(3'd4, 32'd13); wr(3'd5, 32'd20);
    wr(3'd0, 32'h1);
    burst(32'h1000, 8, 1'b0, 0, "R2");
    burst(32'h1020, 5, 1'b1, 0, "R5");
    stop_engine(32'h1000, 8);
  endtask

  // staged values ignored until update request
  task automatic t_update;
    wr(3'd4, 32'd16); wr(3'd5, 32'd16);
    wr(3'd0, 32'h1);
    burst(32'h1000, 8, 1'b0, 0, "R7");
    wr(3'd1, 32'h2000); wr(3'd3, 32'd9); wr(3'd2, 32'd12);
    check(!upd_pending, "R7", upd_pending, 0);
    burst(32'h1020, 8, 1'b1, 0, "R7");
    wait_req("R7");
    check(req_addr == 32'h1000, "R7", req_addr, 32'h1000);
    check(req_pixoff == 5'd3, "R7", req_pixoff, 3);
    wr(3'd0, 32'h3);
    check(upd_pending, "R6", upd_pending, 1);
    burst(32'h1000, 8, 1'b0, 0, "R6");
    check(upd_pending, "R6", upd_pending, 1);
    burst(32'h1020, 8, 1'b1, 0, "R6");
    check(!upd_pending, "R6", upd_pending, 0);
    wait_req("R6");
    check(req_pixoff == 5'd9, "R6", req_pixoff, 9);
    stop_engine(32'h2000, 8);
  endtask

  // 3-word bursts, 5-word lines, skip 12 bytes from the updated values
  task automatic t_short_burst;
    wr(3'd6, 32'd2); wr(3'd5, 32'd5); wr(3'd4, 32'd10);
    wr(3'd0, 32'h1);
    burst(32'h2000, 3, 1'b0, 0, "R2");
    burst(32'h200C, 2, 1'b0, 0, "R4");
    burst(32'h2020, 3, 1'b0, 1, "R4");
    burst(32'h202C, 2, 1'b1, 0, "R5");
    stop_engine(32'h2000, 3);
  endtask

  initial begin
    cfg_we = 1'b0; cfg_sel = '0; cfg_wdata = '0;
    req_ready = 1'b0; rsp_done = 1'b0;
    rst_n = 1'b0;
    repeat (3) @(negedge clk);
    t_reset();
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_line_walk();
    t_frame_clip();
    t_update();
    t_short_burst();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fails);
    $finish;
  end

  initial begin
    repeat (WDOG_CYCLES) @(posedge clk);
    n_checks++;
    n_fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fails);
    $finish;
  end

endmodule